// File: doc/BRIEF.md
# Ring Port Loop-Back Router

This block steers byte-wide frame streams among two to four logical ports that form a ring, plus one slot for the frame processing unit. Every port is either open or closed. An open port sends the stream that reaches it out on its own transmit side. It then feeds its own receive stream onward to the next port in ring order. A closed port passes the arriving stream straight on to the next port and drops its own receive stream. A closed port's transmit side stays idle.

The processing unit sits on the way into port 0. When port 0 is open, its receive stream goes to the processing unit. The unit's output then enters the ring at port 1 and continues through ports 2 and 3. It finally reaches port 0's transmit side, or goes back into the processing unit if port 0 is closed. A port is closed when the master-written loop control says so, when its link is down under an automatic mode, or when the port is not available in the build. A new open/closed decision is applied only between frames. Every output stream is registered once.

Top module: `rrl_ring_router`

## Requirements
- R1: While reset is asserted, every transmit valid and the processing-unit input valid are low, all ports read back closed, and the control register reads zero.
- R2: Port k's loop control is the 2-bit field cfg[2k+1:2k]. With value 00 (automatic), the port is open exactly when its link is up.
- R3: With value 01 (automatic close), the port closes when its link goes down. It stays closed after the link returns, and reopens only after a write of 01 to its field while the link is up.
- R4: With value 10 the port is open whatever its link state. With value 11 it is closed whatever its link state.
- R5: A port whose bit in the AVAIL_MASK parameter is 0 is always closed, whatever its field and link.
- R6: A stream from the processing unit goes out on the first open port among 1 to NPORT-1, in increasing order. If none is open, it goes to port 0's transmit side when port 0 is open, and back into the processing unit otherwise. Port 0's receive stream goes to the processing unit when port 0 is open.
- R7: The receive stream of open port k (k ≥ 1) continues to the first open port after k. If there is none, it goes to port 0's transmit side or to the processing unit, as in R6.
- R8: A closed port's transmit side never carries a beat, and frames received on a closed port reach no output.
- R9: Each routed beat appears at its single destination one cycle after it is presented, with its data and last flag unchanged.
- R10: A change of a port's open/closed state takes effect only when no frame is in flight on the stream arriving at that port or on its receive stream. A frame that has started finishes on its original route.
- R11: The status outputs give each port's applied open state and its link state one cycle delayed. The control register reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the loop control register |
| cfg_wdata | input | 2*NPORT | Loop control write data, 2 bits per port |
| cfg_rdata | output | 2*NPORT | Loop control register readback |
| link_up | input | NPORT | Link status per port |
| rx_valid | input | NPORT | Receive beat valid per port |
| rx_data | input | NPORT*DW | Receive data, port k at bits [k*DW +: DW] |
| rx_last | input | NPORT | Last beat of a received frame |
| tx_valid | output | NPORT | Transmit beat valid per port |
| tx_data | output | NPORT*DW | Transmit data, port k at bits [k*DW +: DW] |
| tx_last | output | NPORT | Last beat of a transmitted frame |
| pu_in_valid | output | 1 | Beat valid toward the processing unit |
| pu_in_data | output | DW | Data toward the processing unit |
| pu_in_last | output | 1 | Last beat toward the processing unit |
| pu_out_valid | input | 1 | Beat valid from the processing unit |
| pu_out_data | input | DW | Data from the processing unit |
| pu_out_last | input | 1 | Last beat from the processing unit |
| stat_open | output | NPORT | Applied open state per port |
| stat_link | output | NPORT | Registered link state per port |

## Verification
Two situations are hard to reach from the ports. The first is a control write that lands in the middle of a frame: the new route must wait until the frame has left, yet the next frame must take it. The bench reaches this with a directed frame that carries a control write on its third beat. It then checks that every beat stays on the old port and that a later frame takes the new route. The second is the sticky closure of the automatic-close mode. This needs a link drop, a link return and a rewrite, in that order. It is driven as a directed sequence and also arises in the random phase, where control writes, link toggles and frames from random sources are mixed.

// File: rtl/rrl_pkg.sv
package rrl_pkg;

   localparam int MAX_PORTS = 4;

   typedef enum logic [1:0] {
      LM_AUTO      = 2'b00,
      LM_AUTOCLOSE = 2'b01,
      LM_OPEN      = 2'b10,
      LM_SHUT      = 2'b11
   } loop_mode_e;

   // open/closed decision for one port from its mode, link and sticky flag
   function automatic logic want_open(loop_mode_e mode, logic link, logic hold);
      logic res;
      case (mode)
         LM_AUTO:      res = link;
         LM_AUTOCLOSE: res = link & ~hold;
         LM_OPEN:      res = 1'b1;
         default:      res = 1'b0;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/rrl_frame_track.sv
module rrl_frame_track (
   input  logic clk,
   input  logic rst_n,
   input  logic beat_valid,
   input  logic beat_last,
   output logic in_frame
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
      end else if (beat_valid) begin
         in_frame <= ~beat_last;
      end
   end

endmodule

// File: rtl/rrl_port_ctrl.sv
module rrl_port_ctrl
   import rrl_pkg::*;
#(
   parameter bit AVAILABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  loop_mode_e mode,
   input  logic       wr_en,
   input  loop_mode_e wr_mode,
   input  logic       link,
   input  logic       arr_valid,
   input  logic       arr_last,
   input  logic       rx_valid,
   input  logic       rx_last,
   output logic       open_q
);

   logic       arr_busy;
   logic       rx_busy;
   logic       hold_q;
   logic       hold_d;
   logic       want;
   logic       idle;
   loop_mode_e next_mode;

   rrl_frame_track u_arr_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (arr_valid),
      .beat_last  (arr_last),
      .in_frame   (arr_busy)
   );

   rrl_frame_track u_rx_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (rx_valid),
      .beat_last  (rx_last),
      .in_frame   (rx_busy)
   );

   // sticky closure of the automatic-close mode
   always_comb begin
      next_mode = wr_en ? wr_mode : mode;
      if (next_mode != LM_AUTOCLOSE) begin
         hold_d = 1'b0;
      end else if (!link) begin
         hold_d = 1'b1;
      end else if (wr_en) begin
         hold_d = 1'b0;
      end else begin
         hold_d = hold_q;
      end
   end

   assign want = AVAILABLE & want_open(mode, link, hold_q);
   assign idle = ~arr_busy & ~rx_busy & ~arr_valid & ~rx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         open_q <= 1'b0;
      end else begin
         hold_q <= hold_d;
         if (idle) begin
            open_q <= want;
         end
      end
   end

endmodule

// File: rtl/rrl_ring_stage.sv
module rrl_ring_stage #(
   parameter int DW = 8
) (
   input  logic          open,
   input  logic          arr_valid,
   input  logic [DW-1:0] arr_data,
   input  logic          arr_last,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_last,
   output logic          tx_valid,
   output logic [DW-1:0] tx_data,
   output logic          tx_last,
   output logic          nxt_valid,
   output logic [DW-1:0] nxt_data,
   output logic          nxt_last
);

   always_comb begin
      if (open) begin
         tx_valid  = arr_valid;
         tx_data   = arr_data;
         tx_last   = arr_last;
         nxt_valid = rx_valid;
         nxt_data  = rx_data;
         nxt_last  = rx_last;
      end else begin
         tx_valid  = 1'b0;
         tx_data   = '0;
         tx_last   = 1'b0;
         nxt_valid = arr_valid;
         nxt_data  = arr_data;
         nxt_last  = arr_last;
      end
   end

endmodule

// File: rtl/rrl_ring_router.sv
module rrl_ring_router
   import rrl_pkg::*;
#(
   parameter int       NPORT      = 4,
   parameter int       DW         = 8,
   parameter bit [3:0] AVAIL_MASK = 4'b1111
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [2*NPORT-1:0]    cfg_wdata,
   output logic [2*NPORT-1:0]    cfg_rdata,
   input  logic [NPORT-1:0]      link_up,
   input  logic [NPORT-1:0]      rx_valid,
   input  logic [NPORT*DW-1:0]   rx_data,
   input  logic [NPORT-1:0]      rx_last,
   output logic [NPORT-1:0]      tx_valid,
   output logic [NPORT*DW-1:0]   tx_data,
   output logic [NPORT-1:0]      tx_last,
   output logic                  pu_in_valid,
   output logic [DW-1:0]         pu_in_data,
   output logic                  pu_in_last,
   input  logic                  pu_out_valid,
   input  logic [DW-1:0]         pu_out_data,
   input  logic                  pu_out_last,
   output logic [NPORT-1:0]      stat_open,
   output logic [NPORT-1:0]      stat_link
);

   localparam int CFGW  = 2 * NPORT;
   localparam int NLINK = NPORT + 1;

   // elaboration-time parameter checks
   generate
      if (NPORT < 2 || NPORT > MAX_PORTS) begin : g_bad_nport
         $error("rrl_ring_router: NPORT must lie in 2..4");
      end
      if (DW < 1) begin : g_bad_dw
         $error("rrl_ring_router: DW must be at least 1");
      end
      if (AVAIL_MASK[0] != 1'b1) begin : g_bad_mask
         $error("rrl_ring_router: port 0 must be available");
      end
   endgenerate

   logic [CFGW-1:0] cfg_q;
   logic [NPORT-1:0] open_vec;

   // ring links: index 0 feeds the processing unit, 1 leaves it,
   // k+1 leaves port k for k >= 1, NPORT arrives at port 0
   logic          lk_valid [NLINK];
   logic [DW-1:0] lk_data  [NLINK];
   logic          lk_last  [NLINK];

   logic          st_valid [NPORT];
   logic [DW-1:0] st_data  [NPORT];
   logic          st_last  [NPORT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         stat_link <= '0;
      end else begin
         if (cfg_we) begin
            cfg_q <= cfg_wdata;
         end
         stat_link <= link_up;
      end
   end

   assign cfg_rdata = cfg_q;
   assign stat_open = open_vec;

   assign lk_valid[1] = pu_out_valid;
   assign lk_data[1]  = pu_out_data;
   assign lk_last[1]  = pu_out_last;

   genvar k;
   generate
      for (k = 0; k < NPORT; k++) begin : g_port
         localparam int AI = (k == 0) ? NPORT : k;
         localparam int NI = (k == 0) ? 0 : k + 1;

         rrl_port_ctrl #(
            .AVAILABLE (AVAIL_MASK[k])
         ) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (loop_mode_e'(cfg_q[2*k +: 2])),
            .wr_en     (cfg_we),
            .wr_mode   (loop_mode_e'(cfg_wdata[2*k +: 2])),
            .link      (link_up[k]),
            .arr_valid (lk_valid[AI]),
            .arr_last  (lk_last[AI]),
            .rx_valid  (rx_valid[k]),
            .rx_last   (rx_last[k]),
            .open_q    (open_vec[k])
         );

         rrl_ring_stage #(
            .DW (DW)
         ) u_stage (
            .open      (open_vec[k]),
            .arr_valid (lk_valid[AI]),
            .arr_data  (lk_data[AI]),
            .arr_last  (lk_last[AI]),
            .rx_valid  (rx_valid[k]),
            .rx_data   (rx_data[k*DW +: DW]),
            .rx_last   (rx_last[k]),
            .tx_valid  (st_valid[k]),
            .tx_data   (st_data[k]),
            .tx_last   (st_last[k]),
            .nxt_valid (lk_valid[NI]),
            .nxt_data  (lk_data[NI]),
            .nxt_last  (lk_last[NI])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_valid[k]          <= 1'b0;
               tx_data[k*DW +: DW]  <= '0;
               tx_last[k]           <= 1'b0;
            end else begin
               tx_valid[k]          <= st_valid[k];
               tx_data[k*DW +: DW]  <= st_data[k];
               tx_last[k]           <= st_last[k];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pu_in_valid <= 1'b0;
         pu_in_data  <= '0;
         pu_in_last  <= 1'b0;
      end else begin
         pu_in_valid <= lk_valid[0];
         pu_in_data  <= lk_data[0];
         pu_in_last  <= lk_last[0];
      end
   end

endmodule

// File: rtl/rrl_ring_router_chk.sv
module rrl_ring_router_chk #(
   parameter int NPORT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPORT-1:0] tx_valid,
   input logic [NPORT-1:0] tx_last,
   input logic [NPORT-1:0] stat_open,
   input logic [NPORT-1:0] stat_link,
   input logic [NPORT-1:0] link_up,
   input logic [NPORT-1:0] rx_valid,
   input logic             pu_in_valid,
   input logic             pu_out_valid
);

   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0;
      end else begin
         seen <= 1'b1;
      end
   end

   // R9
   no_dup_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({tx_valid, pu_in_valid}) <= $countones($past({rx_valid, pu_out_valid})));

   // R11
   link_status_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      stat_link == $past(link_up));

   genvar k;
   generate
      for (k = 0; k < NPORT; k++) begin : g_chk
         // R8
         closed_tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[k] |-> $past(stat_open[k]));

         // R10
         frame_route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid[k] && !tx_last[k]) |=> $stable(stat_open[k]));
      end
   endgenerate

endmodule

bind rrl_ring_router rrl_ring_router_chk #(
   .NPORT (NPORT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_valid     (tx_valid),
   .tx_last      (tx_last),
   .stat_open    (stat_open),
   .stat_link    (stat_link),
   .link_up      (link_up),
   .rx_valid     (rx_valid),
   .pu_in_valid  (pu_in_valid),
   .pu_out_valid (pu_out_valid)
);

// File: tb/rrl_ring_router_tb_top.sv
`timescale 1ns/1ps
module rrl_ring_router_tb_top;

   localparam int       N   = 4;
   localparam int       DW  = 8;
   localparam bit [3:0] AV  = 4'b1011;
   localparam int       PU  = N;
   localparam int       DROP = N + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [2*N-1:0]    cfg_wdata = '0;
   logic [2*N-1:0]    cfg_rdata;
   logic [N-1:0]      link_up = '0;
   logic [N-1:0]      rx_valid = '0;
   logic [N*DW-1:0]   rx_data = '0;
   logic [N-1:0]      rx_last = '0;
   logic [N-1:0]      tx_valid;
   logic [N*DW-1:0]   tx_data;
   logic [N-1:0]      tx_last;
   logic              pu_in_valid;
   logic [DW-1:0]     pu_in_data;
   logic              pu_in_last;
   logic              pu_out_valid = 1'b0;
   logic [DW-1:0]     pu_out_data = '0;
   logic              pu_out_last = 1'b0;
   logic [N-1:0]      stat_open;
   logic [N-1:0]      stat_link;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [2*N-1:0] m_cfg = '0;
   logic [N-1:0]   m_hold = '0;

   always #2.5 clk = ~clk;

   rrl_ring_router #(
      .NPORT      (N),
      .DW         (DW),
      .AVAIL_MASK (AV)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .link_up      (link_up),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_last      (rx_last),
      .tx_valid     (tx_valid),
      .tx_data      (tx_data),
      .tx_last      (tx_last),
      .pu_in_valid  (pu_in_valid),
      .pu_in_data   (pu_in_data),
      .pu_in_last   (pu_in_last),
      .pu_out_valid (pu_out_valid),
      .pu_out_data  (pu_out_data),
      .pu_out_last  (pu_out_last),
      .stat_open    (stat_open),
      .stat_link    (stat_link)
   );

   function automatic logic [N-1:0] exp_open();
      logic [N-1:0] v;
      for (int k = 0; k < N; k++) begin
         case (m_cfg[2*k +: 2])
            2'b00:   v[k] = link_up[k];
            2'b01:   v[k] = link_up[k] & ~m_hold[k];
            2'b10:   v[k] = 1'b1;
            default: v[k] = 1'b0;
         endcase
         v[k] = v[k] & AV[k];
      end
      return v;
   endfunction

   function automatic int route(int src, logic [N-1:0] op);
      int start;
      if (src == PU) begin
         start = 1;
      end else if (!op[src]) begin
         return DROP;
      end else if (src == 0) begin
         return PU;
      end else begin
         start = src + 1;
      end
      for (int k = start; k < N; k++) begin
         if (op[k]) return k;
      end
      return op[0] ? 0 : PU;
   endfunction

   task automatic cfg_apply(logic [2*N-1:0] wd);
      m_cfg = wd;
      for (int k = 0; k < N; k++) begin
         m_hold[k] = (wd[2*k +: 2] == 2'b01) ? ~link_up[k] : 1'b0;
      end
   endtask

   task automatic cfg_write(logic [2*N-1:0] wd);
      cfg_we = 1'b1;
      cfg_wdata = wd;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      cfg_apply(wd);
   endtask

   task automatic set_link(int k, logic v);
      link_up[k] = v;
      if (m_cfg[2*k +: 2] == 2'b01 && !v) m_hold[k] = 1'b1;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic check_status(string tag);
      logic [N-1:0] ev;
      ev = exp_open();
      checks++;
      if (stat_open !== ev || stat_link !== link_up || cfg_rdata !== m_cfg) begin
         errors++;
         $display("FAIL %s status: open=%b link=%b cfg=%h expected open=%b link=%b cfg=%h",
                  tag, stat_open, stat_link, cfg_rdata, ev, link_up, m_cfg);
      end
   endtask

   task automatic send_frame(int src, int len, bit midwr, logic [2*N-1:0] mwd, string tag);
      int dest;
      dest = route(src, exp_open());
      for (int i = 0; i < len; i++) begin
         logic [DW-1:0] b;
         logic          lst;
         bit            bad;
         b   = DW'($urandom);
         lst = (i == len - 1);
         if (src == PU) begin
            pu_out_valid = 1'b1;
            pu_out_data  = b;
            pu_out_last  = lst;
         end else begin
            rx_valid[src]          = 1'b1;
            rx_data[src*DW +: DW]  = b;
            rx_last[src]           = lst;
         end
         if (midwr && i == 2) begin
            cfg_we = 1'b1;
            cfg_wdata = mwd;
         end
         @(posedge clk); #1;
         cfg_we = 1'b0;
         bad = 1'b0;
         for (int k = 0; k < N; k++) begin
            if (tx_valid[k] !== (dest == k)) bad = 1'b1;
            if (dest == k && (tx_data[k*DW +: DW] !== b || tx_last[k] !== lst)) bad = 1'b1;
         end
         if (pu_in_valid !== (dest == PU)) bad = 1'b1;
         if (dest == PU && (pu_in_data !== b || pu_in_last !== lst)) bad = 1'b1;
         checks++;
         if (bad) begin
            errors++;
            $display("FAIL %s R9: src=%0d beat=%0d tx_valid=%b pu_in_valid=%b data=%h expected dest=%0d data=%h",
                     tag, src, i, tx_valid, pu_in_valid, tx_data, dest, b);
         end
      end
      pu_out_valid = 1'b0;
      pu_out_last  = 1'b0;
      rx_valid     = '0;
      rx_last      = '0;
      if (midwr) cfg_apply(mwd);
      repeat (2) @(posedge clk);
      #1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: cycles=%0d expected completion before 60000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      // R1: state during reset
      checks++;
      if (tx_valid !== '0 || pu_in_valid !== 1'b0 || stat_open !== '0 || cfg_rdata !== '0) begin
         errors++;
         $display("FAIL R1: tx_valid=%b pu_in_valid=%b open=%b cfg=%h expected all zero",
                  tx_valid, pu_in_valid, stat_open, cfg_rdata);
      end
      rst_n = 1'b1;
      settle();

      // R2: automatic mode follows link
      link_up = 4'b1111;
      cfg_write(8'h00);
      settle();
      check_status("R2 links up");
      send_frame(PU, 4, 0, '0, "R6 pu to port1");
      send_frame(1, 3, 0, '0, "R7 port1 skips absent port2");
      send_frame(3, 2, 0, '0, "R7 port3 to port0");
      send_frame(0, 3, 0, '0, "R6 port0 to pu");
      set_link(1, 1'b0);
      settle();
      check_status("R2 link1 down");
      send_frame(PU, 3, 0, '0, "R2 bypass port1");

      // R4: forced open with link down, forced closed with link up
      cfg_write(8'hC8);
      settle();
      check_status("R4 forced");
      send_frame(PU, 3, 0, '0, "R4 forced open port1");
      send_frame(1, 2, 0, '0, "R4 forced closed port3");

      // R5: unavailable port stays closed when forced open
      cfg_write(8'hE8);
      settle();
      check_status("R5 absent port");
      send_frame(1, 3, 0, '0, "R5 absent port2 bypassed");

      // R8: frame on a closed port is dropped
      send_frame(3, 3, 0, '0, "R8 closed rx dropped");

      // R6: all closed loops back to the processing unit
      cfg_write(8'hFF);
      settle();
      check_status("R6 all closed");
      send_frame(PU, 3, 0, '0, "R6 loop to pu");
      send_frame(0, 2, 0, '0, "R8 closed port0 rx");

      // R3: sticky automatic close
      set_link(1, 1'b1);
      cfg_write(8'hA6);
      settle();
      check_status("R3 armed");
      set_link(1, 1'b0);
      settle();
      check_status("R3 link lost");
      set_link(1, 1'b1);
      settle();
      check_status("R3 stays closed");
      send_frame(PU, 3, 0, '0, "R3 still bypassed");
      cfg_write(8'hA6);
      settle();
      check_status("R3 rearmed");
      send_frame(PU, 3, 0, '0, "R3 reopened");

      // R10: mid-frame change waits for the frame boundary
      cfg_write(8'hCA);
      settle();
      check_status("R10 before");
      send_frame(PU, 6, 1, 8'hCE, "R10 in-flight route");
      settle();
      check_status("R10 after");
      send_frame(PU, 3, 0, '0, "R10 new route");

      // random phase
      for (int it = 0; it < 150; it++) begin
         int act;
         act = $urandom_range(0, 9);
         if (act < 3) begin
            cfg_write(8'($urandom));
         end else if (act < 5) begin
            set_link($urandom_range(0, N - 1), 1'($urandom));
         end
         settle();
         check_status("R11 random");
         send_frame($urandom_range(0, N), $urandom_range(1, 5), 0, '0, "R7 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule